// File: doc/BRIEF.md
# General-Purpose I/O Port Controller with Atomic Pin Update

This block controls a port of digital pins through a small word-addressed register bank. Each pin is placed in one of four modes (digital input, driven output, peripheral-routed output, or analog) and can be given a push-pull or an open-drain output type. The pad itself is outside the block. Each pin is seen as three signals: a value to drive, an enable to drive it, and the value sensed on the wire.

Software changes single pins without a read-modify-write sequence. It writes a set/clear word, either through the register bus or through a dedicated atomic-update port that a second agent (for example an interrupt-side controller) can use in the same cycle as the bus. In peripheral mode, each pin takes its data from one of sixteen peripheral signals, chosen by a per-pin selector. The open-drain or push-pull choice still shapes how that data reaches the pad. Pad values are brought back through a two-flop synchronizer into a readable sample register.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every pin is in input mode with push-pull type, the output latch is 0, every peripheral selector is 0, and no pad output enable is asserted.
- R2: Writing a set/clear word (bus address 4, or the atomic port) with bit k = 1 for k in 0..15 makes latch bit k 1 after that clock edge. Latch bits whose set and clear bits are both 0 keep their value.
- R3: Bit 16+k = 1 in a set/clear word clears latch bit k. Zero bits in either half change nothing.
- R4: When one set/clear word, or the two set/clear sources together, request both set and clear of pin k, pin k ends at 1.
- R5: Reading address 4 (set/clear) always returns 0.
- R6: If a bus write to the latch (address 2) and an atomic-port set/clear fall on the same clock edge, the set/clear is applied on top of the value written by the bus.
- R7: In output mode (mode field 01) with push-pull type (type bit 0), the pad output enable is 1 and the pad value equals the latch bit, for both latch values.
- R8: In open-drain type (type bit 1, address 1 bit k), the pad value is 0, and the output enable is 1 only when the pin's data is 0. When the data is 1, the pin floats.
- R9: In peripheral mode (mode field 10), pin data is peripheral signal af_sig[s]. Here s is the 4-bit selector of pin k, held in address 5 bits [4k+3:4k] for pins 0..7 and in address 6 bits [4(k-8)+3:4(k-8)] for pins 8..15. The output type still applies.
- R10: In input mode (00) and analog mode (11), the pad output enable is 0.
- R11: The sample register (address 3) shows a pad change after the second rising clock edge, and not after the first.
- R12: A pin in analog mode reads 0 in the sample register, whatever its pad value.
- R13: The mode register (address 0, pin k in bits [2k+1:2k]), the type register (address 1), the latch (address 2) and the selectors read back what was written. A bus write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register write address |
| bus_wdata | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| atom_we | input | 1 | Atomic set/clear strobe |
| atom_data | input | 32 | Atomic set/clear word: low half sets, high half clears |
| af_sig | input | 16 | Peripheral output signals available for routing |
| pad_in | input | 16 | Value sensed on each pad |
| pad_out | output | 16 | Value to drive on each pad |
| pad_oe | output | 16 | Drive enable for each pad |

## Verification
The hardest situation to reach is a collision in a single cycle: the bus writes the latch while the atomic port sets and clears pins, and the two sources overlap on the same pins. A single bus cannot produce this. The bench drives both strobes on the same falling edge, so both take effect on the next rising edge. It chooses a bus value and a set/clear word in which some pins are overwritten and some are changed by the set/clear. For the synchronizer, the pad value changes on a falling edge, and the sample register is read both after one rising edge and after two.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      PM_INPUT  = 2'b00,
      PM_OUTPUT = 2'b01,
      PM_ALTFN  = 2'b10,
      PM_ANALOG = 2'b11
   } pin_mode_e;

   // Register word addresses
   localparam int unsigned REG_MODE   = 0;
   localparam int unsigned REG_OTYPE  = 1;
   localparam int unsigned REG_LATCH  = 2;
   localparam int unsigned REG_SAMPLE = 3;
   localparam int unsigned REG_SETCLR = 4;
   localparam int unsigned REG_AFSEL0 = 5;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_chk_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) begin
            stage_q[i] <= '0;
         end
      end else begin
         stage_q[0] <= din;
         for (int i = 1; i < STAGES; i++) begin
            stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned AF_W     = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   input  logic                     atom_we,
   input  logic [2*NUM_PINS-1:0]    atom_data,
   output logic [2*NUM_PINS-1:0]    mode_q,
   output logic [NUM_PINS-1:0]      otype_q,
   output logic [NUM_PINS-1:0]      latch_q,
   output logic [NUM_PINS*AF_W-1:0] afsel_q
);

   localparam int unsigned PINS_PER_AFW = DATA_W / AF_W;
   localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(REG_MODE);
   localparam logic [ADDR_W-1:0] A_OTYPE  = ADDR_W'(REG_OTYPE);
   localparam logic [ADDR_W-1:0] A_LATCH  = ADDR_W'(REG_LATCH);
   localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(REG_SETCLR);

   logic                wr_mode, wr_otype, wr_latch, wr_setclr;
   logic [NUM_PINS-1:0] latch_base, set_vec, clr_vec, latch_next;

   assign wr_mode   = bus_we && (bus_addr == A_MODE);
   assign wr_otype  = bus_we && (bus_addr == A_OTYPE);
   assign wr_latch  = bus_we && (bus_addr == A_LATCH);
   assign wr_setclr = bus_we && (bus_addr == A_SETCLR);

   // Bus value first, then set/clear from both sources, set last
   always_comb begin
      latch_base = wr_latch ? bus_wdata[NUM_PINS-1:0] : latch_q;
      set_vec    = '0;
      clr_vec    = '0;
      if (wr_setclr) begin
         set_vec = set_vec | bus_wdata[NUM_PINS-1:0];
         clr_vec = clr_vec | bus_wdata[NUM_PINS +: NUM_PINS];
      end
      if (atom_we) begin
         set_vec = set_vec | atom_data[NUM_PINS-1:0];
         clr_vec = clr_vec | atom_data[NUM_PINS +: NUM_PINS];
      end
      latch_next = (latch_base & ~clr_vec) | set_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         otype_q <= '0;
         latch_q <= '0;
      end else begin
         if (wr_mode)  mode_q  <= bus_wdata[2*NUM_PINS-1:0];
         if (wr_otype) otype_q <= bus_wdata[NUM_PINS-1:0];
         latch_q <= latch_next;
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_afsel
      localparam int unsigned WORD = p / PINS_PER_AFW;
      localparam int unsigned SLOT = p % PINS_PER_AFW;
      localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'(REG_AFSEL0 + WORD);
      logic [AF_W-1:0] sel_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q <= '0;
         end else if (bus_we && (bus_addr == A_WORD)) begin
            sel_q <= bus_wdata[SLOT*AF_W +: AF_W];
         end
      end
      assign afsel_q[p*AF_W +: AF_W] = sel_q;
   end

   AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((latch_q & $past(set_vec)) == $past(set_vec))); // R4

   AST_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_vec) |=> ((latch_q & $past(clr_vec & ~set_vec)) == '0)); // R3

   AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_latch |=> (((latch_q ^ $past(latch_q)) & ~$past(set_vec | clr_vec)) == '0)); // R2

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
   import gpio_port_pkg::*;
#(
   parameter int unsigned AF_COUNT = 16,
   parameter int unsigned AF_W     = 4
) (
   input  logic [1:0]          mode,
   input  logic                open_drain,
   input  logic                latch,
   input  logic [AF_W-1:0]     af_sel,
   input  logic [AF_COUNT-1:0] af_sig,
   output logic                pad_out,
   output logic                pad_oe
);

   logic af_bit;
   logic data;
   logic active;

   always_comb begin
      af_bit = 1'b0;
      for (int i = 0; i < AF_COUNT; i++) begin
         if (af_sel == AF_W'(i)) af_bit = af_sig[i];
      end
   end

   always_comb begin
      data   = 1'b0;
      active = 1'b0;
      case (pin_mode_e'(mode))
         PM_OUTPUT: begin data = latch;  active = 1'b1; end
         PM_ALTFN:  begin data = af_bit; active = 1'b1; end
         default:   begin data = 1'b0;   active = 1'b0; end
      endcase
   end

   always_comb begin
      if (!active) begin
         pad_out = 1'b0;
         pad_oe  = 1'b0;
      end else if (open_drain) begin
         pad_out = 1'b0;
         pad_oe  = ~data;
      end else begin
         pad_out = data;
         pad_oe  = 1'b1;
      end
   end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned AF_COUNT    = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   input  logic                  atom_we,
   input  logic [2*NUM_PINS-1:0] atom_data,
   input  logic [AF_COUNT-1:0]   af_sig,
   input  logic [NUM_PINS-1:0]   pad_in,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pad_oe
);

   localparam int unsigned AF_W         = (AF_COUNT > 1) ? $clog2(AF_COUNT) : 1;
   localparam int unsigned PINS_PER_AFW = DATA_W / AF_W;
   localparam int unsigned AF_WORDS     = (NUM_PINS + PINS_PER_AFW - 1) / PINS_PER_AFW;
   localparam int unsigned AFW_BITS     = PINS_PER_AFW * AF_W;
   localparam int unsigned AF_PAD_W     = AF_WORDS * AFW_BITS;

   if (NUM_PINS < 1 || 2*NUM_PINS > DATA_W) begin : g_chk_pins
      $error("gpio_port_ctrl: NUM_PINS must be 1..DATA_W/2");
   end
   if (AF_COUNT < 1 || AF_W > DATA_W) begin : g_chk_af
      $error("gpio_port_ctrl: AF_COUNT out of range");
   end
   if (REG_AFSEL0 + AF_WORDS > (1 << ADDR_W)) begin : g_chk_addr
      $error("gpio_port_ctrl: ADDR_W too small for selector words");
   end

   logic [2*NUM_PINS-1:0]    mode_q;
   logic [NUM_PINS-1:0]      otype_q;
   logic [NUM_PINS-1:0]      latch_q;
   logic [NUM_PINS*AF_W-1:0] afsel_q;
   logic [NUM_PINS-1:0]      sync_q;
   logic [NUM_PINS-1:0]      analog_mask;
   logic [NUM_PINS-1:0]      idle_mask;
   logic [NUM_PINS-1:0]      in_vis;
   logic [AF_PAD_W-1:0]      af_pad;

   gpio_port_regs #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .AF_W     (AF_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .atom_we   (atom_we),
      .atom_data (atom_data),
      .mode_q    (mode_q),
      .otype_q   (otype_q),
      .latch_q   (latch_q),
      .afsel_q   (afsel_q)
   );

   gpio_in_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (sync_q)
   );

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      assign analog_mask[k] = (mode_q[2*k +: 2] == 2'(PM_ANALOG));
      assign idle_mask[k]   = (mode_q[2*k] == mode_q[2*k+1]);

      gpio_pin_drive #(
         .AF_COUNT (AF_COUNT),
         .AF_W     (AF_W)
      ) u_drv (
         .mode       (mode_q[2*k +: 2]),
         .open_drain (otype_q[k]),
         .latch      (latch_q[k]),
         .af_sel     (afsel_q[k*AF_W +: AF_W]),
         .af_sig     (af_sig),
         .pad_out    (pad_out[k]),
         .pad_oe     (pad_oe[k])
      );
   end

   assign in_vis = sync_q & ~analog_mask;
   assign af_pad = AF_PAD_W'(afsel_q);

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(REG_MODE))   rd_data = DATA_W'(mode_q);
      if (rd_addr == ADDR_W'(REG_OTYPE))  rd_data = DATA_W'(otype_q);
      if (rd_addr == ADDR_W'(REG_LATCH))  rd_data = DATA_W'(latch_q);
      if (rd_addr == ADDR_W'(REG_SAMPLE)) rd_data = DATA_W'(in_vis);
      for (int w = 0; w < AF_WORDS; w++) begin
         if (rd_addr == ADDR_W'(REG_AFSEL0 + w)) rd_data = DATA_W'(af_pad[w*AFW_BITS +: AFW_BITS]);
      end
   end

   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & otype_q & pad_out) == '0); // R8

   AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & idle_mask) == '0); // R10

   AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe | otype_q | idle_mask) == '1); // R7

   AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(REG_SAMPLE)) |-> ((rd_data[NUM_PINS-1:0] & analog_mask) == '0)); // R12

endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        atom_we = 1'b0;
   logic [31:0] atom_data = '0;
   logic [15:0] af_sig = '0;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out;
   logic [15:0] pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_port_ctrl u_gpio_port_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .atom_we   (atom_we),
      .atom_data (atom_data),
      .af_sig    (af_sig),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(3'd0, v); check("R1 mode", v, 32'h0);
      rd(3'd1, v); check("R1 type", v, 32'h0);
      rd(3'd2, v); check("R1 latch", v, 32'h0);
      rd(3'd5, v); check("R1 sel lo", v, 32'h0);
      rd(3'd6, v); check("R1 sel hi", v, 32'h0);
      check("R1 oe", {16'h0, pad_oe}, 32'h0);
   endtask

   task automatic t_set;
      logic [31:0] v;
      wr(3'd4, 32'h0000_0008);
      rd(3'd2, v); check("R2 single set", v, 32'h0008);
      wr(3'd4, 32'h0000_8100);
      rd(3'd2, v); check("R2 set keeps others", v, 32'h8108);
   endtask

   task automatic t_clear;
      logic [31:0] v;
      wr(3'd4, 32'h0008_0000);
      rd(3'd2, v); check("R3 clear", v, 32'h8100);
      wr(3'd4, 32'h0000_0000);
      rd(3'd2, v); check("R3 zero word", v, 32'h8100);
   endtask

   task automatic t_both;
      logic [31:0] v;
      wr(3'd4, 32'h0120_0120);
      rd(3'd2, v); check("R4 set wins", v, 32'h8120);
      rd(3'd4, v); check("R5 set/clear reads 0", v, 32'h0);
   endtask

   task automatic t_same_cycle;
      logic [31:0] v;
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h0000_00FF;
      atom_we = 1'b1; atom_data = 32'h0001_1000;
      @(negedge clk);
      bus_we = 1'b0; atom_we = 1'b0; atom_data = '0;
      rd(3'd2, v); check("R6 bus then set/clear", v, 32'h10FE);
      @(negedge clk);
      atom_we = 1'b1; atom_data = 32'h0004_0000;
      bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h0000_0004;
      @(negedge clk);
      bus_we = 1'b0; atom_we = 1'b0; atom_data = '0;
      rd(3'd2, v); check("R4 two sources set wins", v, 32'h10FE);
   endtask

   task automatic t_push_pull;
      logic [31:0] v;
      wr(3'd0, 32'h5555_5555);
      wr(3'd1, 32'h0);
      rd(3'd0, v); check("R13 mode readback", v, 32'h5555_5555);
      check("R7 oe", {16'h0, pad_oe}, 32'hFFFF);
      check("R7 out", {16'h0, pad_out}, 32'h10FE);
   endtask

   task automatic t_open_drain;
      logic [31:0] v;
      wr(3'd1, 32'h0000_FFFF);
      rd(3'd1, v); check("R13 type readback", v, 32'hFFFF);
      check("R8 oe", {16'h0, pad_oe}, 32'hEF01);
      check("R8 out", {16'h0, pad_out}, 32'h0);
   endtask

   task automatic t_alt;
      logic [31:0] v;
      wr(3'd1, 32'h0);
      wr(3'd0, 32'hAAAA_AAAA);
      wr(3'd5, 32'h7654_3210);
      wr(3'd6, 32'hFEDC_BA98);
      rd(3'd6, v); check("R13 sel readback", v, 32'hFEDC_BA98);
      @(negedge clk); af_sig = 16'hA5C3; #1;
      check("R9 identity out", {16'h0, pad_out}, 32'hA5C3);
      check("R9 identity oe", {16'h0, pad_oe}, 32'hFFFF);
      wr(3'd5, 32'h0);
      af_sig = 16'h0001; #1;
      check("R9 shared select", {16'h0, pad_out}, 32'h00FF);
      wr(3'd5, 32'h7654_3210);
      wr(3'd1, 32'h0000_FFFF);
      af_sig = 16'hA5C3; #1;
      check("R9 open-drain oe", {16'h0, pad_oe}, 32'h5A3C);
      check("R9 open-drain out", {16'h0, pad_out}, 32'h0);
      wr(3'd1, 32'h0);
   endtask

   task automatic t_idle;
      wr(3'd0, 32'h0);
      check("R10 input oe", {16'h0, pad_oe}, 32'h0);
      wr(3'd0, 32'hFFFF_FFFF);
      check("R10 analog oe", {16'h0, pad_oe}, 32'h0);
      wr(3'd0, 32'h0);
   endtask

   task automatic t_sync;
      logic [31:0] v;
      @(negedge clk); pad_in = 16'h0;
      repeat (3) @(negedge clk);
      pad_in = 16'h1234;
      @(negedge clk);
      rd(3'd3, v); check("R11 one edge", v, 32'h0);
      @(negedge clk);
      rd(3'd3, v); check("R11 two edges", v, 32'h1234);
   endtask

   task automatic t_analog;
      logic [31:0] v;
      pad_in = 16'hFFFF;
      wr(3'd0, 32'h0000_FFFF);
      repeat (3) @(negedge clk);
      rd(3'd3, v); check("R12 analog reads 0", v, 32'hFF00);
      wr(3'd0, 32'h0);
   endtask

   task automatic t_sample_write;
      logic [31:0] v;
      wr(3'd3, 32'h0000_0000);
      rd(3'd3, v); check("R13 sample write ignored", v, 32'hFFFF);
      rd(3'd2, v); check("R13 latch untouched", v, 32'h10FE);
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=complete");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set();
      t_clear();
      t_both();
      t_same_cycle();
      t_push_pull();
      t_open_drain();
      t_alt();
      t_idle();
      t_sync();
      t_analog();
      t_sample_write();
      done = 1'b1;
      finish_run();
   end

endmodule